// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a logical address, given as a choice of one of six segment registers plus a 32-bit offset, into a 32-bit linear address. It holds the six 16-bit selectors itself. On a start pulse it reads the chosen selector. Bit 2 of the selector decides whether the global or the local descriptor table base is used. The index field is scaled by eight and added to that table base, which gives the address of an 8-byte descriptor in memory.

The descriptor is read through a simple request/response port as two 32-bit words. The lower word is read first, and the memory may take any number of cycles to answer each read. The 32-bit segment base is built from four of the descriptor's bytes and added to the offset. A one-cycle done pulse then presents the result. A translation runs from start to done, and no second translation can begin before done.

Top module: `seg_xlate`

## Requirements
- R1: `segWrEn` with `segWrSel` = 0..5 writes `segWrData` into selector register 0..5 (code, stack, data, extra 1, extra 2, extra 3). Codes 6 and 7 write nothing. A translation that uses `segSel` 6 or 7 uses the selector value 0.
- R2: Selector bit 2 chooses the table base. 0 uses `globalBase` and 1 uses `localBase`.
- R3: The first read address is the chosen table base plus (selector bits 15:3) times 8, modulo 2^32. Selector bits 1:0 have no effect.
- R4: Each translation issues exactly two one-cycle read requests. The second request comes at the first address plus 4, and only after the response to the first request has been accepted.
- R5: The segment base is {hi[31:24], hi[7:0], lo[31:16]}, where lo is the first response word and hi is the second. This is descriptor bytes 7, 4, 3, 2 in little-endian order.
- R6: `linAddr` equals the segment base plus `offset`, modulo 2^32. It is valid in the cycle `done` is high.
- R7: `done` is a one-cycle pulse in the cycle after the second response is accepted.
- R8: A `startValid` while `busy` is high is ignored. It causes no extra requests and no extra done pulse.
- R9: After reset, `busy`, `done` and `memReqValid` are 0 and all six selector registers hold 0.
- R10: The first read request appears in the cycle after the edge that accepts `startValid`. A response is accepted no earlier than the cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Write strobe for a selector register |
| segWrSel | input | 3 | Selector register to write (0..5) |
| segWrData | input | 16 | Selector value to write |
| startValid | input | 1 | Start a translation (ignored while busy) |
| segSel | input | 3 | Segment register used by the translation |
| offset | input | 32 | Offset within the segment |
| globalBase | input | 32 | Global descriptor table base |
| localBase | input | 32 | Local descriptor table base |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle result pulse |
| linAddr | output | 32 | Linear address, valid with done |
| memReqValid | output | 1 | One-cycle read request |
| memReqAddr | output | 32 | Read address |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response word |

## Verification
The assertions check on every cycle that requests are single-cycle pulses raised only while busy. They also check that the second address is the first plus four and that done is a lone pulse directly after a response. A checker recomputes the base-plus-offset sum from the words seen on the response port and compares it with `linAddr` at done. Only the bench scenarios can show the things that depend on stored state: the table choice and index scaling for particular selector values, the aliasing of codes 6 and 7, reset contents, and that a start during a long memory wait leaves no trace.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LO,
    ST_WAIT_LO,
    ST_REQ_HI,
    ST_WAIT_HI,
    ST_FINISH
  } xlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture descriptor address and offset
    logic captureLo;  // store first response word
    logic captureHi;  // store second response word
    logic selHiAddr;  // present second word address
  } dpCtrl_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  input  logic    memRspValid,
  output logic    memReqValid,
  output logic    busy,
  output logic    done,
  output dpCtrl_t ctrl
);

  xlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (startValid) nextState = ST_REQ_LO;
      ST_REQ_LO:  nextState = ST_WAIT_LO;
      ST_WAIT_LO: if (memRspValid) nextState = ST_REQ_HI;
      ST_REQ_HI:  nextState = ST_WAIT_HI;
      ST_WAIT_HI: if (memRspValid) nextState = ST_FINISH;
      ST_FINISH:  nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl.latchReq  = (state == ST_IDLE) && startValid;
    ctrl.captureLo = (state == ST_WAIT_LO) && memRspValid;
    ctrl.captureHi = (state == ST_WAIT_HI) && memRspValid;
    ctrl.selHiAddr = (state == ST_REQ_HI);
  end

  assign memReqValid = (state == ST_REQ_LO) || (state == ST_REQ_HI);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FINISH);

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SEL_W    = 16,
  parameter int NUM_SEGS = 6,
  parameter int SEG_ID_W = 3,
  parameter int TI_BIT   = 2,
  parameter int DESC_SH  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                segWrEn,
  input  logic [SEG_ID_W-1:0] segWrSel,
  input  logic [SEL_W-1:0]    segWrData,
  input  logic [SEG_ID_W-1:0] segSel,
  input  logic [ADDR_W-1:0]   offset,
  input  logic [ADDR_W-1:0]   globalBase,
  input  logic [ADDR_W-1:0]   localBase,
  input  logic [ADDR_W-1:0]   memRspData,
  input  dpCtrl_t             ctrl,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [ADDR_W-1:0]   linAddr
);

  localparam int WORD_BYTES = ADDR_W / 8;
  localparam logic [SEL_W-1:0] IDX_MASK = ~SEL_W'((1 << DESC_SH) - 1);

  logic [SEL_W-1:0]  segReg [NUM_SEGS];
  logic [SEL_W-1:0]  selNow;
  logic [ADDR_W-1:0] descAddr, offReg, loWord, hiWord, segBase;

  // selector registers, one per segment
  for (genvar g = 0; g < NUM_SEGS; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN)
        segReg[g] <= '0;
      else if (segWrEn && segWrSel == SEG_ID_W'(g))
        segReg[g] <= segWrData;
    end
  end

  // codes without a register read as a zero selector
  always_comb begin
    selNow = '0;
    for (int i = 0; i < NUM_SEGS; i++)
      if (segSel == SEG_ID_W'(i)) selNow = segReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr <= '0;
      offReg   <= '0;
      loWord   <= '0;
      hiWord   <= '0;
    end else begin
      if (ctrl.latchReq) begin
        // index times eight is the selector with its low bits cleared
        descAddr <= (selNow[TI_BIT] ? localBase : globalBase)
                    + ADDR_W'(selNow & IDX_MASK);
        offReg   <= offset;
      end
      if (ctrl.captureLo) loWord <= memRspData;
      if (ctrl.captureHi) hiWord <= memRspData;
    end
  end

  assign memReqAddr = ctrl.selHiAddr ? descAddr + ADDR_W'(WORD_BYTES) : descAddr;
  assign segBase    = {hiWord[31:24], hiWord[7:0], loWord[31:16]};
  assign linAddr    = segBase + offReg;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SEL_W    = 16,
  parameter int NUM_SEGS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [2:0]        segWrSel,
  input  logic [SEL_W-1:0]  segWrData,
  input  logic              startValid,
  input  logic [2:0]        segSel,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] globalBase,
  input  logic [ADDR_W-1:0] localBase,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] linAddr,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  dpCtrl_t ctrl;

  seg_xlate_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .memRspValid (memRspValid),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done),
    .ctrl        (ctrl)
  );

  seg_xlate_dp #(
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .NUM_SEGS (NUM_SEGS),
    .SEG_ID_W (3)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .segWrEn    (segWrEn),
    .segWrSel   (segWrSel),
    .segWrData  (segWrData),
    .segSel     (segSel),
    .offset     (offset),
    .globalBase (globalBase),
    .localBase  (localBase),
    .memRspData (memRspData),
    .ctrl       (ctrl),
    .memReqAddr (memReqAddr),
    .linAddr    (linAddr)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [ADDR_W-1:0] offset,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] linAddr,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [ADDR_W-1:0] memRspData
);

  logic [1:0]        reqNum;
  logic [ADDR_W-1:0] firstAddr, offSeen, loSeen, hiSeen;
  logic              accepted;

  assign accepted = startValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqNum    <= '0;
      firstAddr <= '0;
      offSeen   <= '0;
      loSeen    <= '0;
      hiSeen    <= '0;
    end else begin
      if (accepted) begin
        reqNum  <= '0;
        offSeen <= offset;
      end else if (memReqValid) begin
        reqNum <= reqNum + 2'd1;
      end
      if (memReqValid && reqNum == 2'd0) firstAddr <= memReqAddr;
      if (memRspValid && reqNum == 2'd1) loSeen <= memRspData;
      if (memRspValid && reqNum == 2'd2) hiSeen <= memRspData;
    end
  end

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy); // R4
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R4
  AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && reqNum == 2'd1) |-> memReqAddr == firstAddr + 32'd4); // R4
  AST_FIRST_REQ_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (memReqValid && reqNum == 2'd0)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(memRspValid) && reqNum == 2'd2)); // R7
  AST_LIN_SUM: assert property (@(posedge clk) disable iff (!rstN)
    done |-> linAddr == {hiSeen[31:24], hiSeen[7:0], loSeen[31:16]} + offSeen); // R6 (base layout R5)
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && busy && !done) |=> busy); // R8

endmodule

bind seg_xlate seg_xlate_chk i_chk (.*);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  logic        clk = 1'b0;
  logic        rstN;
  logic        segWrEn;
  logic [2:0]  segWrSel;
  logic [15:0] segWrData;
  logic        startValid;
  logic [2:0]  segSel;
  logic [31:0] offset, globalBase, localBase;
  logic        busy, done;
  logic [31:0] linAddr;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;

  seg_xlate i_seg_xlate (.*);

  always #4 clk = ~clk;

  int nChk = 0, nFail = 0;
  int cycle = 0;
  int rspLat = 1;
  int startCycle = 0, lastRspCycle = 0;
  int doneSeen = 0, doneWanted = 0;
  bit reqPhase = 0;
  logic [15:0] shadow [8];
  logic [31:0] expAddr[$];
  logic [31:0] expLin[$];
  string       expTag[$];

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
  endfunction

  task automatic writeSeg(input logic [2:0] sel, input logic [15:0] data);
    segWrEn = 1'b1; segWrSel = sel; segWrData = data;
    @(negedge clk);
    segWrEn = 1'b0;
    if (sel < 3'd6) shadow[sel] = data;
  endtask

  // driver: pushes expected addresses and result, then pulses start
  task automatic translate(input logic [2:0] seg, input logic [31:0] off, input int lat, input string tag);
    logic [15:0] s;
    logic [31:0] da, lo, hi;
    while (busy) @(negedge clk);
    s  = shadow[seg];
    da = (s[2] ? localBase : globalBase) + {16'd0, s[15:3], 3'b000};
    lo = memWord(da);
    hi = memWord(da + 32'd4);
    expAddr.push_back(da);
    expAddr.push_back(da + 32'd4);
    expLin.push_back({hi[31:24], hi[7:0], lo[31:16]} + off);
    expTag.push_back(tag);
    doneWanted++;
    rspLat = lat;
    startCycle = cycle;
    segSel = seg; offset = off; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  // memory responder with address checks
  initial begin
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (rstN && memReqValid) begin
        logic [31:0] a, ea;
        a = memReqAddr;
        if (expAddr.size() == 0) begin
          check(1'b0, "R8 unexpected request", a, 32'h0);
        end else begin
          ea = expAddr.pop_front();
          check(a == ea, reqPhase ? "R4 second read address" : "R2 R3 descriptor address", a, ea);
          if (!reqPhase)
            check(cycle == startCycle + 1, "R10 first request timing", cycle, startCycle + 1);
        end
        reqPhase = ~reqPhase;
        repeat (rspLat) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = memWord(a);
        lastRspCycle = cycle;
      end
    end
  end

  // monitor: compares results as they appear
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        logic [31:0] e;
        string t;
        doneSeen++;
        check(cycle == lastRspCycle + 1, "R7 done timing", cycle, lastRspCycle + 1);
        if (expLin.size() == 0) begin
          check(1'b0, "R8 unexpected done", linAddr, 32'h0);
        end else begin
          e = expLin.pop_front();
          t = expTag.pop_front();
          check(linAddr == e, {t, " R5 R6 linear address"}, linAddr, e);
        end
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", done, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cycle, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    rstN = 1'b0; segWrEn = 0; segWrSel = 0; segWrData = 0;
    startValid = 0; segSel = 0; offset = 0;
    globalBase = 32'h0010_0000; localBase = 32'h0020_0400;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R9 busy after reset", busy, 0);
    check(done == 1'b0, "R9 done after reset", done, 0);
    check(memReqValid == 1'b0, "R9 no request after reset", memReqValid, 0);
    translate(3'd0, 32'h0000_1234, 1, "R9 zero selector");
    translate(3'd5, 32'h0000_0040, 2, "R9 zero selector");

    writeSeg(3'd0, 16'h0008);   // index 1, global
    writeSeg(3'd1, 16'h001C);   // index 3, local
    writeSeg(3'd2, 16'h002F);   // index 5, local, low bits set
    writeSeg(3'd3, 16'hFFF8);   // top index, global
    writeSeg(3'd4, 16'hFFFC);   // top index, local
    writeSeg(3'd5, 16'h0013);   // index 2, global, low bits set
    writeSeg(3'd6, 16'h1234);   // no register: ignored

    translate(3'd0, 32'h0000_0100, 1, "R1 R2 global");
    translate(3'd1, 32'hABCD_0000, 3, "R2 local");
    translate(3'd2, 32'h0000_0007, 1, "R3 low bits ignored");
    translate(3'd3, 32'h7FFF_FFFF, 4, "R3 top index");
    translate(3'd4, 32'hFFFF_FFFF, 2, "R6 wrap");
    translate(3'd5, 32'h8000_0000, 1, "R3 low bits ignored");
    translate(3'd6, 32'h0000_0555, 1, "R1 code 6 zero selector");
    translate(3'd7, 32'h0000_0AAA, 2, "R1 code 7 zero selector");

    // start during a long wait must be ignored
    translate(3'd1, 32'h0000_2000, 6, "R8 first");
    @(negedge clk);
    segSel = 3'd3; offset = 32'hDEAD_BEEF; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    translate(3'd2, 32'h0000_3000, 1, "R8 after ignored start");

    // table base near the top wraps the descriptor address
    while (busy) @(negedge clk);
    localBase = 32'hFFFF_FFF8;
    translate(3'd1, 32'h0000_0010, 1, "R3 address wrap");

    while (busy || expLin.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(doneSeen == doneWanted, "R8 done count", doneSeen, doneWanted);
    check(expAddr.size() == 0, "R4 all requests seen", expAddr.size(), 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule